// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

This block gathers interrupt requests from a set of maskable sources and from one non-maskable source and picks one of them for a CPU-side acceptance unit. Each maskable source has a three-bit priority level that is written through a small write-only configuration port. A rising edge on a source line sets that source's pending flag. A source is eligible only when its flag is set and its level is between 1 and 6. Levels 0 and 7 both turn the source off.

The arbiter looks at every pending, eligible request combinationally in each cycle. It presents the highest level together with the vector of the source that holds it. The non-maskable source needs no configuration and always ranks above every maskable level. When the CPU pulses the acknowledge, the arbiter clears the pending flag of the source it is presenting in that cycle. The vector stays stable for the whole acknowledge cycle, so the CPU can take it as the vector read.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset all levels are 0, no flag is pending and `req_valid_o` is 0.
- R2: A maskable flag is set only by a low-to-high change of its line that is seen at a clock edge. A line held high after its request was acknowledged raises no new request.
- R3: A source whose level is 0 or 7 does not capture edges and is never presented. A presented maskable level always lies in the range 1 to 6.
- R4: `req_level_o` carries the highest level among the eligible pending sources. `req_vec_o` carries that source's vector, which is VEC_BASE + VEC_STEP × index (0x20 + 4 × index by default).
- R5: When eligible pending sources share the top level, the source with the smallest index wins. That source also has the smallest vector.
- R6: An `ack_i` pulse while `req_valid_o` is 1 clears only the presented source's flag. `req_vec_o` and `req_level_o` hold steady in the acknowledge cycle, and the remaining requests are presented afterwards.
- R7: A non-maskable edge is presented as level 8 with vector NMI_VEC (0x08 by default). It wins over every maskable level, and no level setting disables it.
- R8: An edge that arrives while the source's flag is already set is absorbed, so a single acknowledge retires both edges.
- R9: An `ack_i` pulse while `req_valid_o` is 0 changes no flag.
- R10: Writing level 0 to a pending source hides it but keeps its flag. Writing an enabling level again brings the request back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Maskable source lines, captured on their rising edge |
| nmi_i | input | 1 | Non-maskable source line, captured on its rising edge |
| cfg_we_i | input | 1 | Level register write strobe |
| cfg_idx_i | input | IDX_W | Index of the source whose level is written |
| cfg_lvl_i | input | 3 | Level value to write |
| ack_i | input | 1 | One-cycle acknowledge (vector read) from the CPU |
| req_valid_o | output | 1 | A request is presented |
| req_level_o | output | 4 | Presented level, 1 to 6 for maskable sources and 8 for the non-maskable source |
| req_vec_o | output | VEC_W | Vector of the presented source |

## Verification
Each source alone is swept through all eight level values. This separates the enabling levels from the two disabling levels, and it shows that every index maps to its own vector. Every pair of sources is then raised in the same cycle with levels chosen so that both orderings and ties occur. This separates a correct comparison from an index-based tie-break that goes the wrong way, and a second acknowledge shows that only the winner was cleared. Further patterns cover a non-maskable request raised together with all eight maskable sources while the levels are rewritten to 0, a repeated edge on a line that is already pending, a line held high, an acknowledge while nothing is presented, and masking and unmasking a pending source.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W = 3;
    localparam int PRES_W = 4;
    localparam logic [PRES_W-1:0] NMI_LEVEL = 4'd8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [PRES_W-1:0] pres_lvl_t;

    function automatic logic lvl_enabled(lvl_t l);
        return (l != 3'd0) && (l != 3'd7);
    endfunction

endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  lvl_t                   lvl_i,
    output lvl_t [N_SRC-1:0]       lvl_o,
    output logic [N_SRC-1:0]       en_o
);

    typedef struct packed {
        lvl_t [N_SRC-1:0] lvl;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i && (int'(idx_i) < N_SRC)) begin
            s_d.lvl[idx_i] = lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o = s_q.lvl;

    for (genvar g = 0; g < N_SRC; g++) begin : g_en
        assign en_o[g] = lvl_enabled(s_q.lvl[g]);
    end

endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] pend;
    } state_t;

    state_t s_d, s_q;
    logic [N_SRC-1:0] rise;

    always_comb begin
        rise      = src_i & ~s_q.prev & en_i;
        s_d.prev  = src_i;
        // a fresh edge in the clearing cycle keeps the flag set
        s_d.pend  = (s_q.pend & ~clr_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;

    assert_capture_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.pend & ~$past(s_q.pend) & ~$past(src_i & ~s_q.prev)) == '0));

    assert_clear_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~rise) != '0) |=> ((s_q.pend & $past(clr_i & ~rise)) == '0));

    assert_hold_without_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i == '0) && (rise == '0)) |=> $stable(s_q.pend));

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
#(
    parameter int N_SRC    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int VEC_STEP = 4,
    parameter int NMI_VEC  = 8
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    input  lvl_t [N_SRC-1:0] lvl_i,
    input  logic             nmi_pend_i,
    output logic             valid_o,
    output pres_lvl_t        level_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N_SRC-1:0] win_oh_o,
    output logic             win_nmi_o
);

    pres_lvl_t best;
    int        widx;
    logic      found;

    always_comb begin
        best  = '0;
        widx  = 0;
        found = 1'b0;
        // strict compare while walking upward keeps the smallest index on ties
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && en_i[i] && ({1'b0, lvl_i[i]} > best)) begin
                best  = {1'b0, lvl_i[i]};
                widx  = i;
                found = 1'b1;
            end
        end

        win_oh_o  = '0;
        win_nmi_o = 1'b0;
        if (nmi_pend_i) begin
            valid_o   = 1'b1;
            level_o   = NMI_LEVEL;
            vec_o     = VEC_W'(NMI_VEC);
            win_nmi_o = 1'b1;
        end else if (found) begin
            valid_o        = 1'b1;
            level_o        = best;
            vec_o          = VEC_W'(VEC_BASE + VEC_STEP * widx);
            win_oh_o[widx] = 1'b1;
        end else begin
            valid_o = 1'b0;
            level_o = '0;
            vec_o   = '0;
        end
    end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int VEC_STEP = 4,
    parameter int NMI_VEC  = 8,
    localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_i,
    input  logic             nmi_i,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [2:0]       cfg_lvl_i,
    input  logic             ack_i,
    output logic             req_valid_o,
    output logic [3:0]       req_level_o,
    output logic [VEC_W-1:0] req_vec_o
);

    lvl_t [N_SRC-1:0] lvl;
    logic [N_SRC-1:0] en;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] win_oh;
    logic [N_SRC-1:0] clr;
    logic             nmi_pend;
    logic             win_nmi;
    logic             nmi_clr;

    irq_level_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (cfg_we_i),
        .idx_i (cfg_idx_i),
        .lvl_i (cfg_lvl_i),
        .lvl_o (lvl),
        .en_o  (en)
    );

    irq_edge_capture #(.N_SRC(N_SRC)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (irq_i),
        .en_i   (en),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_edge_capture #(.N_SRC(1)) u_nmi_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (nmi_i),
        .en_i   (1'b1),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    irq_select #(
        .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP), .NMI_VEC(NMI_VEC)
    ) u_sel (
        .pend_i     (pend),
        .en_i       (en),
        .lvl_i      (lvl),
        .nmi_pend_i (nmi_pend),
        .valid_o    (req_valid_o),
        .level_o    (req_level_o),
        .vec_o      (req_vec_o),
        .win_oh_o   (win_oh),
        .win_nmi_o  (win_nmi)
    );

    assign clr     = ack_i ? win_oh : '0;
    assign nmi_clr = ack_i & win_nmi;

    assert_disabled_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && (req_level_o != NMI_LEVEL)) |-> ((req_level_o >= 4'd1) && (req_level_o <= 4'd6)));

    assert_nmi_on_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> (req_valid_o && (req_level_o == NMI_LEVEL) && (req_vec_o == VEC_W'(NMI_VEC))));

    assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_oh, win_nmi}) && (req_valid_o == ((win_oh != '0) || win_nmi)));

endmodule

// File: tb/sim_prio_irq_arbiter.sv
module sim_prio_irq_arbiter;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] irq = '0;
    logic       nmi = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [2:0] cfg_lvl = '0;
    logic       ack = 1'b0;
    logic       valid;
    logic [3:0] level;
    logic [7:0] vec;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prio_irq_arbiter #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_lvl_i(cfg_lvl),
        .ack_i(ack), .req_valid_o(valid), .req_level_o(level), .req_vec_o(vec)
    );

    function automatic logic [7:0] vec_of(int i);
        return 8'(32 + 4 * i);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_req(string req, logic v, int l, int vv);
        check(req, int'(valid), int'(v));
        if (v) begin
            check(req, int'(level), l);
            check(req, int'(vec), vv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_lvl(int i, int l);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_lvl = 3'(l);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(logic [N-1:0] m, logic n);
        irq = m; nmi = n;
        tick();
        irq = '0; nmi = 1'b0;
        tick();
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check("R1 valid after reset", int'(valid), 0);

        // R3 and R4: single source sweep over all levels
        for (int i = 0; i < N; i++) begin
            for (int l = 0; l < 8; l++) begin
                set_lvl(i, l);
                pulse(N'(1) << i, 1'b0);
                if (l == 0 || l == 7) begin
                    expect_req("R3 disabled level", 1'b0, 0, 0);
                end else begin
                    expect_req("R4 single source", 1'b1, l, vec_of(i));
                    do_ack();
                    expect_req("R6 cleared after ack", 1'b0, 0, 0);
                end
            end
            set_lvl(i, 0);
        end

        // R4, R5, R6: every pair raised together
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                int li, lj, w, o, lw, lo;
                li = 1 + (i * 3 + j) % 6;
                lj = 1 + (j * 5 + i) % 6;
                set_lvl(i, li);
                set_lvl(j, lj);
                pulse((N'(1) << i) | (N'(1) << j), 1'b0);
                if (lj > li) begin w = j; o = i; lw = lj; lo = li; end
                else begin w = i; o = j; lw = li; lo = lj; end
                expect_req(li == lj ? "R5 tie to smaller index" : "R4 higher level wins", 1'b1, lw, vec_of(w));
                ack = 1'b1;
                check("R6 vector stable in ack cycle", int'(vec), int'(vec_of(w)));
                #3;
                check("R6 vector stable in ack cycle", int'(vec), int'(vec_of(w)));
                tick();
                ack = 1'b0;
                expect_req("R6 other source remains", 1'b1, lo, vec_of(o));
                do_ack();
                expect_req("R6 all cleared", 1'b0, 0, 0);
                set_lvl(i, 0);
                set_lvl(j, 0);
            end
        end

        // R7: non-maskable request above everything, unaffected by levels
        for (int i = 0; i < N; i++) set_lvl(i, 6);
        pulse('1, 1'b1);
        expect_req("R7 nmi wins", 1'b1, 8, 8);
        for (int i = 0; i < N; i++) set_lvl(i, 0);
        expect_req("R7 nmi not disabled by levels", 1'b1, 8, 8);
        do_ack();
        // R10: pending flags hidden while disabled
        expect_req("R10 hidden while level 0", 1'b0, 0, 0);
        for (int i = 0; i < N; i++) set_lvl(i, 6);
        for (int k = 0; k < N; k++) begin
            expect_req("R5 equal levels drain by index", 1'b1, 6, vec_of(k));
            do_ack();
        end
        expect_req("R6 drained", 1'b0, 0, 0);

        // R8: second edge while pending is absorbed
        set_lvl(2, 4);
        pulse(8'h04, 1'b0);
        pulse(8'h04, 1'b0);
        expect_req("R8 pending once", 1'b1, 4, vec_of(2));
        do_ack();
        expect_req("R8 one ack retires both edges", 1'b0, 0, 0);

        // R2: line held high raises no new request
        set_lvl(5, 3);
        irq = 8'h20;
        tick();
        expect_req("R2 edge captured", 1'b1, 3, vec_of(5));
        do_ack();
        tick(); tick();
        expect_req("R2 held line no re-request", 1'b0, 0, 0);
        irq = '0;
        tick();
        expect_req("R2 falling edge no request", 1'b0, 0, 0);

        // R9: ack with nothing presented leaves hidden flags alone
        set_lvl(1, 5);
        pulse(8'h02, 1'b0);
        set_lvl(1, 0);
        expect_req("R9 hidden before idle ack", 1'b0, 0, 0);
        do_ack();
        do_ack();
        set_lvl(1, 5);
        expect_req("R9 flag survives idle ack", 1'b1, 5, vec_of(1));
        do_ack();
        expect_req("R9 cleared by real ack", 1'b0, 0, 0);

        // R10: re-enable a pending source at a different level
        set_lvl(4, 3);
        pulse(8'h10, 1'b0);
        set_lvl(4, 7);
        expect_req("R10 hidden at level 7", 1'b0, 0, 0);
        set_lvl(4, 2);
        expect_req("R10 back at new level", 1'b1, 2, vec_of(4));
        do_ack();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule